// File: doc/BRIEF.md
# Coprocessor Bus Request and Cycle Sequencer

This block lets a numeric coprocessor borrow the host's local bus to move one operand to or from memory. A transfer strobe carries the address, the write data and the direction. The sequencer asks the host for the bus with a one-clock low pulse on a shared request/grant line. It then waits for the host's one-clock grant pulse on the same line. After the grant it runs a bus cycle through the states T1, T2, T3, any wait states and T4. When the transfer is finished it returns the bus with a one-clock release pulse and then stops driving its outputs.

The lower address bits and the data share one set of lines. The upper address bits share their lines with status bits. A 3-bit code tells the rest of the system the cycle type. READY stretches the cycle with wait states. If a new strobe arrives in T4, the next cycle follows at once and the bus is not handed back in between. Read data is captured from the bus and is shown on `rd_data_o` together with the done strobe.

Top module: `cop_bus_seq`

## Requirements
- R1: After reset, and whenever the bus is not owned, `ad_oe_o`, `ctl_oe_o`, `rq_pull_o` and `done_o` are low, `status_o` is 111, `ad_o` is 0 and `hi_o` is 0111.
- R2: A strobe on `xfer_req_i` while idle makes `rq_pull_o` high (pulling the shared line low) in the next cycle, for exactly one cycle.
- R3: After the request pulse, the block drives nothing until it sees the line low. T1 starts in the cycle after the grant is seen, however many cycles the grant takes.
- R4: In T1, `ad_oe_o` and `ctl_oe_o` are high, `ad_o` carries address bits [15:0] and `hi_o` carries address bits [19:16].
- R5: In a write, `ad_o` carries the write data with `ad_oe_o` high in T2, T3, every wait state and T4.
- R6: In a read, `ad_oe_o` is low from T2 to T4. `ad_i` is captured in the last T3 or wait cycle, the one in which READY is high, and appears on `rd_data_o` from T4 onward.
- R7: `status_o` is 101 for a read and 110 for a write from T1 through the last wait state. It is 111 in T4, in the release cycle and while idle.
- R8: Outside T1, `hi_o` is 0111: bit 3 (S6) is low and bits 2..0 (S5, S4, S3) are high.
- R9: READY low in T3 or in a wait state adds one more wait state. READY high there leads to T4 on the next cycle.
- R10: `done_o` is high for exactly one cycle per transfer, in T4.
- R11: A strobe in T4 starts the next transfer at T1 in the next cycle, with the new operands and no release or request pulse.
- R12: After a T4 with no new strobe, the next cycle is a release cycle: `rq_pull_o` high for one cycle with `ctl_oe_o` still high and `ad_oe_o` low. All output enables are low in the cycle after that.
- R13: Strobes outside idle and T4, including those in T2 and in the release cycle, are ignored: the running transfer keeps its operands and no new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Transfer strobe, one cycle |
| xfer_wr_i | input | 1 | 1 = memory write, 0 = memory read |
| xfer_addr_i | input | 20 | Operand address |
| xfer_data_i | input | 16 | Write data |
| rq_line_i | input | 1 | Level sensed on the shared request/grant line, low = pulse |
| rq_pull_o | output | 1 | 1 = pull the shared line low this cycle |
| ready_i | input | 1 | Memory ready; low inserts wait states |
| ad_i | input | 16 | Data sensed on the multiplexed lines |
| ad_o | output | 16 | Address or data driven on the multiplexed lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| hi_o | output | 4 | Upper address bits in T1, status bits otherwise |
| status_o | output | 3 | Bus cycle status code |
| ctl_oe_o | output | 1 | Output enable for `hi_o` and `status_o` while the bus is owned |
| done_o | output | 1 | Transfer finished (T4) |
| rd_data_o | output | 16 | Last data read |

## Verification
The chained transfer is the hardest case to reach from the ports. The next strobe must land in the one T4 cycle, and that cycle depends on the grant delay and on the number of wait states. The bench reaches it by building every transfer one cycle at a time from a behavioural model. The model knows when T4 comes and raises the strobe there. Other strobes are placed on purpose in T2 and in the release cycle, to show that they change nothing at the ports.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [2:0] {A_IDLE, A_REQ, A_WAIT, A_OWN, A_REL} arb_e;
  typedef enum logic [2:0] {T_IDLE, T_1, T_2, T_3, T_W, T_4} tst_e;
  localparam logic [2:0] ST_RD   = 3'b101;
  localparam logic [2:0] ST_WR   = 3'b110;
  localparam logic [2:0] ST_PASS = 3'b111;
endpackage

// File: rtl/cbm_arb.sv
module cbm_arb
  import cbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rq_line_i,
  input  logic cyc_last_i,
  output logic start_o,
  output logic rq_pull_o,
  output logic own_o,
  output arb_e state_o
);
  arb_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      A_IDLE: if (req_i) st_d = A_REQ;
      A_REQ:  st_d = A_WAIT;
      A_WAIT: if (!rq_line_i) st_d = A_OWN;
      A_OWN:  if (cyc_last_i) st_d = A_REL;
      A_REL:  st_d = A_IDLE;
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= A_IDLE;
    else         st_q <= st_d;

  assign start_o   = (st_q == A_WAIT) && !rq_line_i;
  assign rq_pull_o = (st_q == A_REQ) || (st_q == A_REL);
  assign own_o     = (st_q == A_OWN) || (st_q == A_REL);
  assign state_o   = st_q;

  // pulses on the shared line last one clock
  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rq_pull_o |=> !rq_pull_o);
  // release is followed by a tri-stated idle bus
  assert_release_then_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == A_REL) |=> (!own_o && st_q == A_IDLE));
endmodule

// File: rtl/cbm_tcyc.sv
module cbm_tcyc
  import cbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic chain_i,
  input  logic ready_i,
  output tst_e state_o,
  output logic last_o,
  output logic capture_o
);
  tst_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      T_IDLE: if (start_i) st_d = T_1;
      T_1:    st_d = T_2;
      T_2:    st_d = T_3;
      T_3, T_W: st_d = ready_i ? T_4 : T_W;
      T_4:    st_d = chain_i ? T_1 : T_IDLE;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= T_IDLE;
    else         st_q <= st_d;

  assign state_o   = st_q;
  assign last_o    = (st_q == T_4) && !chain_i;
  assign capture_o = ((st_q == T_3) || (st_q == T_W)) && ready_i;

  assert_wait_inserted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == T_3 || st_q == T_W) && !ready_i) |=> (st_q == T_W));
  assert_chain_to_t1_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_4 && chain_i) |=> (st_q == T_1));
endmodule

// File: rtl/cbm_drive.sv
module cbm_drive
  import cbm_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_i,
  input  tst_e          tst_i,
  input  logic          capture_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] hi_o,
  output logic [2:0]    status_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int HW = AW - DW;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;
  logic          wr_q;
  logic          in_t1, in_data, active;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      wr_q   <= wr_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                rd_q <= '0;
    else if (capture_i && !wr_q) rd_q <= ad_i;

  assign in_t1   = (tst_i == T_1);
  assign in_data = (tst_i == T_2) || (tst_i == T_3) || (tst_i == T_W) || (tst_i == T_4);
  assign active  = in_t1 || (tst_i == T_2) || (tst_i == T_3) || (tst_i == T_W);

  always_comb begin
    if (in_t1)                ad_o = addr_q[DW-1:0];
    else if (in_data && wr_q) ad_o = data_q;
    else                      ad_o = '0;
  end

  assign ad_oe_o  = in_t1 || (in_data && wr_q);
  assign status_o = !active ? ST_PASS : (wr_q ? ST_WR : ST_RD);
  assign done_o   = (tst_i == T_4);
  assign rd_data_o = rd_q;

  // upper lines: address in T1, fixed status pattern otherwise (top bit low)
  for (genvar i = 0; i < HW; i++) begin : g_hi
    localparam logic STAT_BIT = (i == HW - 1) ? 1'b0 : 1'b1;
    assign hi_o[i] = in_t1 ? addr_q[DW+i] : STAT_BIT;
  end

  assert_passive_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == ST_PASS));
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cop_bus_seq.sv
module cop_bus_seq
  import cbm_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_req_i,
  input  logic          xfer_wr_i,
  input  logic [AW-1:0] xfer_addr_i,
  input  logic [DW-1:0] xfer_data_i,
  input  logic          rq_line_i,
  output logic          rq_pull_o,
  input  logic          ready_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] hi_o,
  output logic [2:0]    status_o,
  output logic          ctl_oe_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o
);
  arb_e arb_st;
  tst_e t_st;
  logic start, cyc_last, capture, load, chain;

  assign chain = xfer_req_i && (t_st == T_4);
  assign load  = (xfer_req_i && arb_st == A_IDLE) || chain;

  cbm_arb u_arb (
    .clk_i, .rst_ni,
    .req_i      (xfer_req_i),
    .rq_line_i,
    .cyc_last_i (cyc_last),
    .start_o    (start),
    .rq_pull_o,
    .own_o      (ctl_oe_o),
    .state_o    (arb_st)
  );

  cbm_tcyc u_tcyc (
    .clk_i, .rst_ni,
    .start_i   (start),
    .chain_i   (xfer_req_i),
    .ready_i,
    .state_o   (t_st),
    .last_o    (cyc_last),
    .capture_o (capture)
  );

  cbm_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk_i, .rst_ni,
    .load_i    (load),
    .addr_i    (xfer_addr_i),
    .data_i    (xfer_data_i),
    .wr_i      (xfer_wr_i),
    .tst_i     (t_st),
    .capture_i (capture),
    .ad_i,
    .ad_o, .ad_oe_o, .hi_o, .status_o, .done_o, .rd_data_o
  );

  assert_t1_after_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_st == A_WAIT && !rq_line_i) |=> (t_st == T_1));
  assert_quiet_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_st == A_IDLE) |-> (!ctl_oe_o && !ad_oe_o && !done_o));
  assert_no_drive_while_waiting_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_st == A_WAIT) |-> (!ctl_oe_o && !ad_oe_o));
endmodule

// File: tb/cop_bus_seq_test.sv
`timescale 1ns/1ps
module cop_bus_seq_test;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic xfer_req = 1'b0, xfer_wr = 1'b0, ready = 1'b1, host_low = 1'b0;
  logic [AW-1:0] xfer_addr = '0;
  logic [DW-1:0] xfer_data = '0, ad_in = '0;
  logic rq_line, rq_pull, ad_oe, ctl_oe, done;
  logic [DW-1:0] ad_out, rd_data;
  logic [3:0] hi;
  logic [2:0] status;
  logic [DW-1:0] exp_rd = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign rq_line = ~(host_low | rq_pull);

  cop_bus_seq #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_req_i(xfer_req), .xfer_wr_i(xfer_wr),
    .xfer_addr_i(xfer_addr), .xfer_data_i(xfer_data), .rq_line_i(rq_line),
    .rq_pull_o(rq_pull), .ready_i(ready), .ad_i(ad_in), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .hi_o(hi), .status_o(status), .ctl_oe_o(ctl_oe),
    .done_o(done), .rd_data_o(rd_data)
  );

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tg, what, act, exp, $time);
    end
  endtask

  // compare this cycle's outputs, then advance one clock
  task automatic tick(input string tg, input logic [15:0] e_ad, input logic e_adoe,
                      input logic [3:0] e_hi, input logic [2:0] e_st, input logic e_ctl,
                      input logic e_rq, input logic e_done);
    chk(tg, "ad_o", 32'(ad_out), 32'(e_ad));
    chk(tg, "ad_oe_o", 32'(ad_oe), 32'(e_adoe));
    chk(tg, "hi_o", 32'(hi), 32'(e_hi));
    chk(tg, "status_o", 32'(status), 32'(e_st));
    chk(tg, "ctl_oe_o", 32'(ctl_oe), 32'(e_ctl));
    chk(tg, "rq_pull_o", 32'(rq_pull), 32'(e_rq));
    chk(tg, "done_o", 32'(done), 32'(e_done));
    chk("R6 read data", "rd_data_o", 32'(rd_data), 32'(exp_rd));
    @(negedge clk);
    xfer_req = 1'b0;
    host_low = 1'b0;
    ready = 1'b1;
  endtask

  task automatic acquire(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w, input int gd);
    xfer_addr = a; xfer_data = d; xfer_wr = w; xfer_req = 1'b1;
    tick("R1 idle strobe", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);
    tick("R2 request pulse", 16'h0, 0, 4'h7, 3'b111, 0, 1, 0);
    for (int k = 0; k <= gd; k++) begin
      if (k == gd) host_low = 1'b1;
      tick("R3 wait for grant", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);
    end
  endtask

  task automatic bus_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w,
                           input int waits, input logic [DW-1:0] rdv, input logic glitch,
                           input logic chain, input logic [AW-1:0] na,
                           input logic [DW-1:0] nd, input logic nw);
    logic [2:0] sc;
    logic [15:0] dv;
    sc = w ? 3'b110 : 3'b101;
    dv = w ? d : 16'h0;
    ad_in = rdv;
    tick("R4/R7 T1", a[15:0], 1, a[19:16], sc, 1, 0, 0);
    if (glitch) begin
      xfer_req = 1'b1; xfer_addr = ~a; xfer_data = ~d; xfer_wr = ~w;
    end
    tick(glitch ? "R13 strobe in T2 ignored" : "R5/R6/R8 T2", dv, w, 4'h7, sc, 1, 0, 0);
    ready = (waits == 0);
    tick("R5/R8 T3", dv, w, 4'h7, sc, 1, 0, 0);
    for (int k = 0; k < waits; k++) begin
      ready = (k == waits - 1);
      tick("R9 wait state", dv, w, 4'h7, sc, 1, 0, 0);
    end
    if (!w) exp_rd = rdv;
    if (chain) begin
      xfer_req = 1'b1; xfer_addr = na; xfer_data = nd; xfer_wr = nw;
    end
    tick("R10/R7 T4", dv, w, 4'h7, 3'b111, 1, 0, 1);
  endtask

  task automatic release_bus();
    xfer_req = 1'b1; xfer_addr = 20'hFFFFF; xfer_wr = 1'b1;
    tick("R12 release pulse", 16'h0, 0, 4'h7, 3'b111, 1, 1, 0);
    tick("R12/R13 tri-stated, no new request", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    tick("R1 in reset", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);
    rst_ni = 1'b1;
    tick("R1 after reset", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);

    // write, immediate grant, no waits, stray strobe in T2
    acquire(20'hA1234, 16'hBEEF, 1'b1, 0);
    bus_cycle(20'hA1234, 16'hBEEF, 1'b1, 0, 16'h0, 1'b1, 1'b0, '0, '0, 1'b0);
    release_bus();
    tick("R1 idle", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);

    // read, delayed grant, two wait states
    acquire(20'h50F0F, 16'h0000, 1'b0, 3);
    bus_cycle(20'h50F0F, 16'h0000, 1'b0, 2, 16'h1357, 1'b0, 1'b0, '0, '0, 1'b0);
    release_bus();

    // write chained to a read in T4 (R11), then release
    acquire(20'h3C0DE, 16'h5A5A, 1'b1, 1);
    bus_cycle(20'h3C0DE, 16'h5A5A, 1'b1, 1, 16'h0, 1'b0, 1'b1, 20'hE7701, 16'h0, 1'b0);
    bus_cycle(20'hE7701, 16'h0, 1'b0, 1, 16'hC3A5, 1'b0, 1'b1, 20'h00042, 16'h9876, 1'b1);
    bus_cycle(20'h00042, 16'h9876, 1'b1, 0, 16'h0, 1'b0, 1'b0, '0, '0, 1'b0);
    release_bus();
    tick("R11 chain ended, idle", 16'h0, 0, 4'h7, 3'b111, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule